// File: doc/BRIEF.md
# Bus-Request Block Transfer Sequencer

This block decides when a memory-transfer engine may own the shared system bus while it moves a block of words. Software loads a word count and a transfer mode, then pulses a start strobe. The sequencer raises a bus request toward the processor. It moves words only while the matching grant is held, or only in cycles where the processor leaves the bus idle. For every word moved it emits a one-cycle transfer strobe. When the final word has gone it emits a one-cycle completion pulse that can serve as an interrupt.

There are three release policies. In block mode the request is held until the whole count has moved. In steal mode the bus is handed back after every single word. In idle-slot mode no request is ever raised, and a word moves only when the processor's bus-busy flag is low. Address generation and the data path sit outside this block. The transfer strobe is what drives them.

Top module: `dmaseq_top`

## Requirements
- R1: After reset, `bus_req_o`, `xfer_o` and `done_o` are all low, and they stay low until a start is accepted.
- R2: While `bus_req_o` is high, `xfer_o` is never high in a cycle where `bus_grant_i` is low.
- R3: With `mode_i` = 0 (block mode), or the spare code 3, the request rises in the cycle after the start. It stays high without a gap until the cycle after the last word. A word moves in every cycle where the grant is present, and exactly the programmed count of words moves, up to the largest count the width allows.
- R4: If the grant is withdrawn in the middle of a block-mode transfer, no word moves and the request stays high. The remaining count is kept, and the transfer resumes when the grant returns. The total number of words is unchanged.
- R5: With `mode_i` = 1 (steal mode), exactly one word moves per grant, and the request is low in the cycle after each word.
- R6: In steal mode the request is raised again only after at least `GAP_CYCLES` cycles (default 1) in which both request and grant were low.
- R7: With `mode_i` = 2 (idle-slot mode), the request is never raised, and a word moves only in cycles where `cpu_busy_i` is low.
- R8: `done_o` is a single-cycle pulse in the cycle directly after the final word. Exactly the programmed number of words precede it.
- R9: A start with a length of zero produces `done_o` in the cycle after the start, with no request and no word.
- R10: A start strobe that arrives while a transfer is active, or during the completion cycle, is ignored, and the programmed count of the running block is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Release policy, sampled with start: 0 block, 1 steal, 2 idle-slot, 3 as block |
| len_i | input | CNT_W | Number of words, sampled with start |
| start_i | input | 1 | Start strobe, accepted only when idle |
| bus_grant_i | input | 1 | Grant from the processor |
| cpu_busy_i | input | 1 | Processor is using the bus this cycle |
| bus_req_o | output | 1 | Bus request to the processor |
| xfer_o | output | 1 | One word moves this cycle |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a grant that disappears in the middle of a block-mode run while words remain. The request must stay up and the count must survive. The bench plays the processor: it grants one cycle after it sees the request, and a scenario can force the grant low for a window chosen relative to the start. A second hard case is a start strobe that arrives mid-run. The bench re-strobes with a different length partway through, and then checks that the word total still equals the first length.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

   typedef enum logic [1:0] {
      XM_BLOCK    = 2'd0,
      XM_STEAL    = 2'd1,
      XM_IDLESLOT = 2'd2,
      XM_SPARE    = 2'd3
   } xfer_mode_t;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_BLOCK,
      SQ_STEAL_REQ,
      SQ_STEAL_GAP,
      SQ_IDLESLOT,
      SQ_DONE
   } seq_state_t;

endpackage

// File: rtl/dmaseq_wordcnt.sv
module dmaseq_wordcnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] len_i,
   input  logic             step_i,
   output logic             last_o,
   output logic             empty_o
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      left_q <= '0;
      else if (load_i) left_q <= len_i;
      else if (step_i) left_q <= left_q - ONE;
   end

   assign last_o  = (left_q == ONE);
   assign empty_o = (left_q == '0);

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |-> !empty_o); // R8

endmodule

// File: rtl/dmaseq_gapwait.sv
module dmaseq_gapwait #(
   parameter int GAP_CYCLES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic grant_i,
   output logic ready_o
);

   if (GAP_CYCLES < 1) begin : g_bad_gap
      $error("dmaseq_gapwait: GAP_CYCLES must be at least 1");
   end

   if (GAP_CYCLES == 1) begin : g_single
      assign ready_o = arm_i && !grant_i;
   end else begin : g_count
      localparam int GW = $clog2(GAP_CYCLES);
      localparam logic [GW-1:0] TOP = GW'(GAP_CYCLES - 1);
      logic [GW-1:0] low_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                low_q <= '0;
         else if (!arm_i || grant_i) low_q <= '0;
         else if (low_q != TOP)      low_q <= low_q + 1'b1;
      end

      assign ready_o = arm_i && !grant_i && (low_q == TOP);
   end

   AST_GAP_GRANT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> !grant_i); // R6

endmodule

// File: rtl/dmaseq_top.sv
module dmaseq_top
   import dmaseq_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int GAP_CYCLES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode_i,
   input  logic [CNT_W-1:0] len_i,
   input  logic             start_i,
   input  logic             bus_grant_i,
   input  logic             cpu_busy_i,
   output logic             bus_req_o,
   output logic             xfer_o,
   output logic             done_o
);

   if (CNT_W < 2) begin : g_bad_width
      $error("dmaseq_top: CNT_W must be at least 2");
   end

   seq_state_t state_q, state_d;
   logic       load, last_word, empty, gap_ready, accept, zero_len;
   xfer_mode_t mode_sel;

   assign mode_sel = xfer_mode_t'(mode_i);
   assign accept   = (state_q == SQ_IDLE) && start_i;
   assign zero_len = (len_i == '0);
   assign load     = accept && !zero_len;

   dmaseq_wordcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .len_i   (len_i),
      .step_i  (xfer_o),
      .last_o  (last_word),
      .empty_o (empty)
   );

   dmaseq_gapwait #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm_i   (state_q == SQ_STEAL_GAP),
      .grant_i (bus_grant_i),
      .ready_o (gap_ready)
   );

   always_comb begin
      unique case (state_q)
         SQ_BLOCK, SQ_STEAL_REQ: xfer_o = bus_grant_i;
         SQ_IDLESLOT:            xfer_o = !cpu_busy_i;
         default:                xfer_o = 1'b0;
      endcase
   end

   assign bus_req_o = (state_q == SQ_BLOCK) || (state_q == SQ_STEAL_REQ);
   assign done_o    = (state_q == SQ_DONE);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SQ_IDLE: begin
            if (accept) begin
               if (zero_len)                   state_d = SQ_DONE;
               else if (mode_sel == XM_STEAL)  state_d = SQ_STEAL_REQ;
               else if (mode_sel == XM_IDLESLOT) state_d = SQ_IDLESLOT;
               else                            state_d = SQ_BLOCK;
            end
         end
         SQ_BLOCK, SQ_IDLESLOT: begin
            if (xfer_o && last_word) state_d = SQ_DONE;
         end
         SQ_STEAL_REQ: begin
            if (xfer_o) state_d = last_word ? SQ_DONE : SQ_STEAL_GAP;
         end
         SQ_STEAL_GAP: begin
            if (gap_ready) state_d = SQ_STEAL_REQ;
         end
         SQ_DONE:  state_d = SQ_IDLE;
         default:  state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SQ_IDLE;
      else        state_q <= state_d;
   end

   AST_GRANT_BEFORE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && xfer_o) |-> bus_grant_i); // R2

   AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_STEAL_REQ && xfer_o) |=> !bus_req_o); // R5

   AST_IDLESLOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_o && !bus_req_o) |-> !cpu_busy_i); // R7

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R8

   AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_o && last_word) |=> (done_o && empty)); // R8

   AST_ZERO_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && zero_len) |=> (done_o && !bus_req_o)); // R9

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && state_q != SQ_IDLE && !xfer_o) |=> $stable(empty)); // R10

endmodule

// File: tb/dmaseq_top_test.sv
module dmaseq_top_test;

   localparam int CNT_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       mode_i = '0;
   logic [CNT_W-1:0] len_i = '0;
   logic             start_i = 1'b0;
   logic             bus_grant_i = 1'b0;
   logic             cpu_busy_i = 1'b0;
   logic             bus_req_o, xfer_o, done_o;

   int n_checks = 0;
   int n_fail   = 0;

   int nx, nd, lx, dc, nreq, bad_grant, bad_busy, bad_drop, bad_gap, bad_hold, bad_contig;

   always #2 clk = ~clk;

   dmaseq_top #(.CNT_W(CNT_W), .GAP_CYCLES(1)) uut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .len_i(len_i),
      .start_i(start_i), .bus_grant_i(bus_grant_i), .cpu_busy_i(cpu_busy_i),
      .bus_req_o(bus_req_o), .xfer_o(xfer_o), .done_o(done_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Bench plays the processor: it grants one cycle after it sees the request,
   // except inside a forced-low window.
   task automatic run_block(input logic [1:0] m, input int len, input int drop_from,
                            input int drop_len, input bit busy_pat, input int restart_at);
      logic prev_req = 1'b0;
      logic prev_x   = 1'b0;
      logic seen_req = 1'b0;
      int   lowcnt   = 0;
      nx = 0; nd = 0; lx = -1; dc = -1; nreq = 0;
      bad_grant = 0; bad_busy = 0; bad_drop = 0; bad_gap = 0; bad_hold = 0; bad_contig = 0;
      for (int c = 0; c < 700; c++) begin
         @(negedge clk);
         start_i     = (c == 0) || (c == restart_at);
         mode_i      = m;
         len_i       = CNT_W'((c == 0) ? len : len + 5);
         bus_grant_i = prev_req && !(c >= drop_from && c < drop_from + drop_len);
         cpu_busy_i  = busy_pat ? (c % 3 != 0) : 1'b0;
         #1;
         if (bus_req_o) nreq++;
         if (xfer_o) begin
            nx++; lx = c;
            if (bus_req_o && !bus_grant_i) bad_grant++;
            if (m == 2'd2 && cpu_busy_i) bad_busy++;
         end
         if (done_o) begin nd++; dc = c; end
         if (m == 2'd1) begin
            if (prev_x && bus_req_o) bad_drop++;
            if (bus_req_o && !prev_req && nx > 0 && lowcnt < 1) bad_gap++;
            if (xfer_o) lowcnt = 0;
            else if (!bus_req_o && !bus_grant_i) lowcnt++;
         end
         if (m == 2'd0 || m == 2'd3) begin
            if (seen_req && !bus_req_o && !done_o && nd == 0) bad_hold++;
            if (bus_req_o && bus_grant_i && !xfer_o) bad_contig++;
         end
         if (bus_req_o) seen_req = 1'b1;
         prev_req = bus_req_o;
         prev_x   = xfer_o;
         if (nd > 0 && c > dc + 3) break;
      end
      @(negedge clk);
      start_i = 1'b0; bus_grant_i = 1'b0; cpu_busy_i = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk); #1;
      check(!bus_req_o, "R1 req after reset", bus_req_o, 0);
      check(!xfer_o, "R1 xfer after reset", xfer_o, 0);
      check(!done_o, "R1 done after reset", done_o, 0);
   endtask

   task automatic t_block;
      run_block(2'd0, 6, -10, 0, 1'b0, -1);
      check(nx == 6, "R3 block word count", nx, 6);
      check(bad_contig == 0, "R3 block contiguous", bad_contig, 0);
      check(bad_hold == 0, "R3 block request held", bad_hold, 0);
      check(bad_grant == 0, "R2 block grant", bad_grant, 0);
      check(nd == 1, "R8 block done count", nd, 1);
      check(dc == lx + 1, "R8 block done timing", dc, lx + 1);
   endtask

   task automatic t_block_pause;
      run_block(2'd0, 8, 4, 3, 1'b0, -1);
      check(nx == 8, "R4 paused word count", nx, 8);
      check(bad_grant == 0, "R4 no word without grant", bad_grant, 0);
      check(bad_hold == 0, "R4 request held in pause", bad_hold, 0);
      check(dc == lx + 1, "R8 paused done timing", dc, lx + 1);
   endtask

   task automatic t_spare_and_max;
      run_block(2'd3, 5, -10, 0, 1'b0, -1);
      check(nx == 5 && bad_hold == 0, "R3 spare code as block", nx, 5);
      run_block(2'd0, 255, -10, 0, 1'b0, -1);
      check(nx == 255, "R3 maximum length", nx, 255);
      check(bad_contig == 0, "R3 maximum contiguous", bad_contig, 0);
   endtask

   task automatic t_steal;
      run_block(2'd1, 4, -10, 0, 1'b0, -1);
      check(nx == 4, "R5 steal word count", nx, 4);
      check(bad_drop == 0, "R5 release after each word", bad_drop, 0);
      check(bad_gap == 0, "R6 idle gap before re-request", bad_gap, 0);
      check(bad_grant == 0, "R2 steal grant", bad_grant, 0);
      check(nd == 1 && dc == lx + 1, "R8 steal done", dc, lx + 1);
   endtask

   task automatic t_idleslot;
      run_block(2'd2, 5, -10, 0, 1'b1, -1);
      check(nx == 5, "R7 idle-slot word count", nx, 5);
      check(nreq == 0, "R7 no request", nreq, 0);
      check(bad_busy == 0, "R7 no word while busy", bad_busy, 0);
      check(nd == 1 && dc == lx + 1, "R8 idle-slot done", dc, lx + 1);
   endtask

   task automatic t_zero;
      run_block(2'd0, 0, -10, 0, 1'b0, -1);
      check(dc == 1 && nd == 1, "R9 zero length done", dc, 1);
      check(nreq == 0, "R9 zero length request", nreq, 0);
      check(nx == 0, "R9 zero length words", nx, 0);
   endtask

   task automatic t_restart;
      run_block(2'd0, 6, -10, 0, 1'b0, 3);
      check(nx == 6, "R10 block restart ignored", nx, 6);
      run_block(2'd1, 3, -10, 0, 1'b0, 5);
      check(nx == 3, "R10 steal restart ignored", nx, 3);
      // strobe during the completion cycle: block of 2 granted from cycle 2, done at cycle 4
      run_block(2'd0, 2, -10, 0, 1'b0, 4);
      check(nx == 2 && nd == 1, "R10 restart in done cycle", nx, 2);
      repeat (12) begin
         @(negedge clk); #1;
         check(!bus_req_o && !done_o, "R10 no second block", bus_req_o, 0);
      end
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_block();
      t_block_pause();
      t_spare_and_max();
      t_steal();
      t_idleslot();
      t_zero();
      t_restart();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule